// File: doc/BRIEF.md
# Return Address Stack

This block is a small last-in, first-out store of return addresses for a single-cycle stack CPU. When the decoder sees a call, it raises the push strobe. In the same cycle, the next-PC logic takes the jump target from the instruction word. The block saves the current program counter plus one, so a later return resumes at the instruction after the call site and needs no offset arithmetic. When the decoder sees a return, it raises the pop strobe. The next-PC logic selects the top entry, which the block presents combinationally, and the pointer steps back at the same clock edge.

Both strobes are plain single-cycle controls, with no valid/ready handshake and no back-pressure. A strobe always completes in the cycle it is raised. A push into a full stack is dropped and leaves a sticky overflow flag. A pop from an empty stack sets a sticky underflow flag, and the top output reads zero. The instruction decoder, the instruction memory and the data stack sit outside this block.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is empty. In that state `empty_o`=1, `full_o`=0, `ovf_o`=0, `udf_o`=0 and `top_o`=0.
- R2: An accepted push stores `pc_i`+1 modulo 2^12. For example, 0xFFF is stored as 0x000. The stored value appears on `top_o` from the cycle after the push edge.
- R3: Entries come back in strict reverse order of their pushes. After a pop, `top_o` shows the entry pushed before the popped one, or 0 when no entry remains.
- R4: A push or a pop raised for one cycle takes effect at that clock edge, with no stall. Back-to-back strobes on consecutive cycles are each honoured.
- R5: `empty_o` is 1 exactly when no entries are held. `full_o` is 1 exactly when 16 entries are held.
- R6: A push while full changes no stored entry and no pointer. It sets `ovf_o`, which stays 1 until reset.
- R7: A pop while empty leaves the stack empty and `top_o` at 0. It sets `udf_o`, which stays 1 until reset.
- R8: When push and pop are both high in one cycle, only the pop acts and the push is ignored.
- R9: Reset is synchronous and active low. Asserting it during operation clears the pointer and both error flags at the next edge, even if a push is also requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 12 | Current program counter |
| push_i | input | 1 | Push strobe from call decode |
| pop_i | input | 1 | Pop strobe from return decode |
| top_o | output | 12 | Top entry (return target), 0 when empty |
| full_o | output | 1 | 16 entries held |
| empty_o | output | 1 | No entries held |
| ovf_o | output | 1 | Sticky: push attempted while full |
| udf_o | output | 1 | Sticky: pop attempted while empty |

## Verification
The hardest state to reach from the ports is a full stack receiving one more push. The bench must then show that the write was truly dropped, not just flagged. The stimulus nests sixteen calls with distinct addresses and issues a seventeenth. It then unwinds all sixteen returns and compares each popped value against a reference stack, so a corrupted top or lower entry shows up. Simultaneous push and pop strobes are driven both on a populated stack and on an empty one, where the underflow must be flagged and the push must still be ignored.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Per-cycle operation decoded from the two strobes and the occupancy.
  typedef struct packed {
    logic do_push;   // push accepted (writes an entry)
    logic do_pop;    // pop accepted (drops the top entry)
    logic ovf_hit;   // push refused because full
    logic udf_hit;   // pop refused because empty
  } ras_op_t;

  function automatic ras_op_t ras_decode(logic push, logic pop,
                                         logic full, logic empty);
    ras_op_t op;
    op.do_pop  = pop & ~empty;
    op.udf_hit = pop & empty;
    op.do_push = push & ~pop & ~full;
    op.ovf_hit = push & ~pop & full;
    return op;
  endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output ras_op_t op_o
);

  // Pop takes priority; a push in the same cycle is discarded.
  always_comb begin
    op_o = ras_decode(push_i, pop_i, full_i, empty_i);
  end

endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ras_op_t       op_i,
  output logic [IW-1:0] wr_idx_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;
  logic          ovf_q;
  logic          udf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (op_i.do_pop)
        cnt_q <= cnt_q - ONE;
      else if (op_i.do_push)
        cnt_q <= cnt_q + ONE;
      if (op_i.ovf_hit) ovf_q <= 1'b1;
      if (op_i.udf_hit) udf_q <= 1'b1;
    end
  end

  assign cnt_m1   = cnt_q - ONE;
  assign wr_idx_o = cnt_q[IW-1:0];
  assign rd_idx_o = cnt_m1[IW-1:0];
  assign full_o   = (cnt_q == FULL_CNT);
  assign empty_o  = (cnt_q == '0);
  assign ovf_o    = ovf_q;
  assign udf_o    = udf_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);

  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (we_i && (wr_idx_i == IW'(g)))
        q_r <= wr_data_i;
    end
    assign ent[g] = q_r;
  end

  // Combinational read so next-PC can select the top in the return cycle.
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IW'(i)) rd_data_o = ent[i];
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pc_i,
  input  logic         push_i,
  input  logic         pop_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         ovf_o,
  output logic         udf_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [W-1:0] INC = W'(1);

  ras_op_t       op;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  link_addr;
  logic [W-1:0]  rd_data;
  logic          full_w;
  logic          empty_w;

  ras_ctrl u_ctrl (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full_w),
    .empty_i (empty_w),
    .op_o    (op)
  );

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .full_o   (full_w),
    .empty_o  (empty_w),
    .ovf_o    (ovf_o),
    .udf_o    (udf_o)
  );

  // Save the address after the call site.
  assign link_addr = pc_i + INC;

  ras_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .we_i      (op.do_push),
    .wr_idx_i  (wr_idx),
    .wr_data_i (link_addr),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  assign top_o   = empty_w ? '0 : rd_data;
  assign full_o  = full_w;
  assign empty_o = empty_w;

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pc_i,
  input logic         push_i,
  input logic         pop_i,
  input logic [W-1:0] top_o,
  input logic         full_o,
  input logic         empty_o,
  input logic         ovf_o,
  input logic         udf_o
);

  // Independent occupancy shadow built from the strobes.
  int sh;
  always_ff @(posedge clk) begin
    if (!rst_n)                         sh <= 0;
    else if (pop_i && sh > 0)           sh <= sh - 1;
    else if (push_i && !pop_i && sh < DEPTH) sh <= sh + 1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (empty_o && !full_o && !ovf_o && !udf_o && top_o == '0));

  a_r2_push_link: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (top_o == W'($past(pc_i) + 1'b1)));

  a_r5_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o == (sh == 0)) && (full_o == (sh == DEPTH)));

  a_r6_ovf_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (ovf_o && full_o && $stable(top_o)));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  a_r7_udf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> (udf_o && empty_o && top_o == '0));

  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_o |=> udf_o);

  a_r8_pop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full_o) |=> !full_o);

endmodule

bind ret_addr_stack ras_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc_i    (pc_i),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .top_o   (top_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .ovf_o   (ovf_o),
  .udf_o   (udf_o)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

  localparam int W = 12;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pc_i = '0;
  logic         push_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] top_o;
  logic         full_o, empty_o, ovf_o, udf_o;

  always #10 clk = ~clk;  // 50 MHz

  ret_addr_stack #(.W(W), .DEPTH(DEPTH)) i_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .push_i(push_i), .pop_i(pop_i),
    .top_o(top_o), .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o),
    .udf_o(udf_o)
  );

  typedef struct packed {
    logic [W-1:0] top;
    logic e, f, o, u;
  } exp_t;

  exp_t         exp_q[$];
  string        tag_q[$];
  logic [W-1:0] stk[$];
  logic         m_ovf, m_udf;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 0;

  function automatic exp_t model_out();
    exp_t x;
    x.top = (stk.size() > 0) ? stk[stk.size()-1] : '0;
    x.e = (stk.size() == 0);
    x.f = (stk.size() == DEPTH);
    x.o = m_ovf;
    x.u = m_udf;
    return x;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(bit ps, bit pp, logic [W-1:0] pc, string tag);
    @(negedge clk);
    rst_n = 1'b1; push_i = ps; pop_i = pp; pc_i = pc;
    if (pp) begin
      if (stk.size() > 0) void'(stk.pop_back());
      else m_udf = 1'b1;
    end else if (ps) begin
      if (stk.size() < DEPTH) stk.push_back(pc + 12'h001);
      else m_ovf = 1'b1;
    end
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  task automatic rst_step(bit ps, string tag);
    @(negedge clk);
    rst_n = 1'b0; push_i = ps; pop_i = 1'b0; pc_i = 12'h055;
    stk.delete(); m_ovf = 1'b0; m_udf = 1'b0;
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  // Monitor: compares 5 ns after each rising edge.
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (top_o !== e.top || empty_o !== e.e || full_o !== e.f ||
            ovf_o !== e.o || udf_o !== e.u) begin
          n_bad++;
          $display("FAIL %s: actual top=%h e=%b f=%b o=%b u=%b expected top=%h e=%b f=%b o=%b u=%b",
                   t, top_o, empty_o, full_o, ovf_o, udf_o,
                   e.top, e.e, e.f, e.o, e.u);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_ovf = 1'b0; m_udf = 1'b0;
    rst_step(1'b0, "R1 reset");
    step(0, 0, 12'h000, "R1 idle after reset");
    // Basic calls and returns
    step(1, 0, 12'h100, "R2 push 100");
    step(1, 0, 12'h200, "R2 R4 push 200");
    step(1, 0, 12'h3A5, "R2 R4 push 3A5");
    step(0, 1, 12'h000, "R3 R4 pop");
    step(0, 1, 12'h000, "R3 pop");
    step(0, 1, 12'h000, "R3 R5 pop to empty");
    step(0, 1, 12'h000, "R7 pop empty");
    step(0, 0, 12'h000, "R7 udf sticky");
    rst_step(1'b0, "R9 reset clears udf");
    step(1, 0, 12'hFFF, "R2 wrap FFF");
    step(0, 1, 12'h000, "R3 pop wrap");
    // Fill, overflow, unwind
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 12'(i * 12'h111 + 12'h007), "R5 fill");
    step(1, 0, 12'hABC, "R6 push while full");
    step(0, 0, 12'h000, "R6 ovf sticky");
    step(1, 1, 12'h777, "R8 push+pop when full");
    step(1, 0, 12'h321, "R5 refill to full");
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, 12'h000, "R6 R3 unwind after ovf");
    // Nested interleave
    step(1, 0, 12'h010, "R3 nest a");
    step(1, 0, 12'h020, "R3 nest b");
    step(0, 1, 12'h000, "R3 ret b");
    step(1, 0, 12'h030, "R3 nest c");
    step(0, 1, 12'h000, "R3 ret c");
    step(1, 1, 12'h040, "R8 push+pop nonempty");
    step(1, 1, 12'h050, "R8 push+pop empty");
    step(0, 0, 12'h000, "R8 idle");
    // Synchronous reset in the middle of activity, with a push requested
    step(1, 0, 12'h600, "R4 push");
    step(1, 0, 12'h601, "R4 push");
    rst_step(1'b1, "R9 reset with push");
    step(0, 0, 12'h000, "R9 idle after reset");
    step(1, 0, 12'h0AA, "R2 push after reset");
    step(0, 0, 12'h000, "R2 idle");
    wait (exp_q.size() == 0);
    @(posedge clk);
    #6;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule